// File: doc/BRIEF.md
# DRAM Refresh and Self-Refresh Sequencer

This block keeps a DDR SDRAM refreshed. A free-running interval timer adds one unit of refresh debt each time the average refresh spacing elapses. As long as debt is owed, the sequencer asks the command arbiter for the command slot. Once the slot is granted, it issues an AUTO REFRESH. If the controller reports open banks, it first issues a PRECHARGE of all banks (A10 high) and waits the precharge period. Refreshes may be postponed while the arbiter is busy. When the debt reaches its ceiling, the request is flagged urgent so the arbiter can put it ahead of all other traffic.

The same sequencer puts the device into self-refresh when the controller asks for it. Banks are closed first if needed. The block then issues the entry command with CKE low and holds CKE low until the request is withdrawn. On exit, CKE is raised and the exit delay is enforced. One AUTO REFRESH is then issued and the interval timer restarts from it. Two ready flags tell the arbiter when non-read commands and read commands are legal again.

Top module: `dram_refresh_seq`

## Requirements
- R1: The interval timer raises the refresh debt by one every T_REFI cycles while the block is not in self-refresh. The debt saturates at MAX_DEBT (8), and ref_urgent_o is high exactly when the debt equals MAX_DEBT.
- R2: In the idle state, ref_req_o is high when the debt is non-zero or sr_req_i is high. It also stays high throughout a precharge wait, a refresh busy period and a self-refresh exit wait. It is low while the device sits in self-refresh.
- R3: A sequence starts only at a clock edge where ref_req_o and grant_i are both high. Its first command appears on cmd_o in the following cycle. The cmd_o encodings are 2'b00 NOP, 2'b01 PRECHARGE-ALL, 2'b10 AUTO REFRESH and 2'b11 SELF REFRESH entry. Each command lasts one cycle.
- R4: If banks_idle_i is low at the grant edge, PRECHARGE-ALL is issued first. The target command then follows exactly T_RP cycles later.
- R5: After an AUTO REFRESH, the sequencer stays busy for T_RFC cycles before it can start again. Each AUTO REFRESH issued from the idle path lowers the debt by one.
- R6: When sr_req_i is high at the start of a sequence, the target is self-refresh entry. cke_o goes low in the same cycle as that command and stays low while sr_req_i is held. The debt is cleared and both ready flags drop.
- R7: When sr_req_i is seen low in self-refresh, cke_o rises in the next cycle. T_XSNR cycles after that rise, an AUTO REFRESH is issued and rdy_nonread_o rises.
- R8: rdy_read_o rises T_XSRD cycles after cke_o rises on self-refresh exit.
- R9: The interval timer restarts at the exit AUTO REFRESH. The next debt unit appears T_REFI cycles after that edge.
- R10: Out of reset, cmd_o is NOP, cke_o is high, both ready flags are high, and ref_req_o and ref_urgent_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; keeps running during self-refresh |
| rst_ni | input | 1 | Asynchronous reset, active low |
| banks_idle_i | input | 1 | High when every bank is precharged |
| sr_req_i | input | 1 | Request to enter, and hold, self-refresh |
| grant_i | input | 1 | Command slot granted by the arbiter |
| ref_req_o | output | 1 | Sequencer needs or owns the command slot |
| ref_urgent_o | output | 1 | Refresh debt at its ceiling |
| cmd_o | output | 2 | Command to issue this cycle |
| cke_o | output | 1 | Clock-enable level for the device |
| rdy_nonread_o | output | 1 | Non-read commands are legal |
| rdy_read_o | output | 1 | READ commands are legal |

## Verification
cmd_o, cke_o and both ready flags come from registers. They change in the cycle after the deciding edge. Each later step lands a fixed number of cycles after that edge: T_RP for the refresh after a precharge, T_RFC for the return to idle, T_XSNR for the exit refresh, T_XSRD for read readiness, and T_REFI for each debt step. ref_req_o and ref_urgent_o follow the state combinationally. The reference model in the bench advances once per rising edge using the inputs held since the previous falling edge. All outputs are compared a quarter period after every rising edge, so each registered result is sampled in the very cycle it is due.

// File: rtl/dram_refresh_pkg.sv
package dram_refresh_pkg;
  typedef enum logic [1:0] {
    CMD_NOP  = 2'b00,
    CMD_PREA = 2'b01,
    CMD_AREF = 2'b10,
    CMD_SREF = 2'b11
  } dram_cmd_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRE_WAIT,
    ST_RFC_WAIT,
    ST_SELF,
    ST_EXIT
  } seq_state_e;
endpackage

// File: rtl/refresh_interval.sv
module refresh_interval #(
  parameter int T_REFI   = 1300,
  parameter int MAX_DEBT = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic dec_i,
  output logic pending_o,
  output logic urgent_o
);
  localparam int TW = $clog2(T_REFI);
  localparam int DW = $clog2(MAX_DEBT + 1);

  logic [TW-1:0] tmr_q;
  logic [DW-1:0] debt_q;
  logic          tick;

  assign tick = (tmr_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tmr_q  <= TW'(T_REFI - 1);
      debt_q <= '0;
    end else if (clr_i) begin
      tmr_q  <= TW'(T_REFI - 1);
      debt_q <= '0;
    end else begin
      tmr_q <= tick ? TW'(T_REFI - 1) : tmr_q - 1'b1;
      unique case ({tick, dec_i})
        2'b10:   if (debt_q != DW'(MAX_DEBT)) debt_q <= debt_q + 1'b1;
        2'b01:   if (debt_q != '0) debt_q <= debt_q - 1'b1;
        default: debt_q <= debt_q;
      endcase
    end
  end

  assign pending_o = (debt_q != '0);
  assign urgent_o  = (debt_q == DW'(MAX_DEBT));

  assert_debt_cap_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (urgent_o && tick && !dec_i && !clr_i) |=> urgent_o);
endmodule

// File: rtl/sr_exit_guard.sv
module sr_exit_guard #(
  parameter int T_XSNR = 13,
  parameter int T_XSRD = 200
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic enter_i,
  input  logic exit_i,
  output logic nr_expire_o,
  output logic rdy_nonread_o,
  output logic rdy_read_o
);
  localparam int NW = $clog2(T_XSNR + 1);
  localparam int RW = $clog2(T_XSRD + 1);

  logic [NW-1:0] nr_cnt_q;
  logic [RW-1:0] rd_cnt_q;
  logic          nr_run_q, rd_run_q;
  logic          nr_rdy_q, rd_rdy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      nr_cnt_q <= '0;
      rd_cnt_q <= '0;
      nr_run_q <= 1'b0;
      rd_run_q <= 1'b0;
      nr_rdy_q <= 1'b1;
      rd_rdy_q <= 1'b1;
    end else if (enter_i) begin
      nr_run_q <= 1'b0;
      rd_run_q <= 1'b0;
      nr_rdy_q <= 1'b0;
      rd_rdy_q <= 1'b0;
    end else if (exit_i) begin
      nr_cnt_q <= NW'(T_XSNR - 1);
      rd_cnt_q <= RW'(T_XSRD - 1);
      nr_run_q <= 1'b1;
      rd_run_q <= 1'b1;
    end else begin
      if (nr_run_q) begin
        if (nr_cnt_q == '0) begin
          nr_run_q <= 1'b0;
          nr_rdy_q <= 1'b1;
        end else begin
          nr_cnt_q <= nr_cnt_q - 1'b1;
        end
      end
      if (rd_run_q) begin
        if (rd_cnt_q == '0) begin
          rd_run_q <= 1'b0;
          rd_rdy_q <= 1'b1;
        end else begin
          rd_cnt_q <= rd_cnt_q - 1'b1;
        end
      end
    end
  end

  assign nr_expire_o   = nr_run_q && (nr_cnt_q == '0);
  assign rdy_nonread_o = nr_rdy_q;
  assign rdy_read_o    = rd_rdy_q;

  assert_read_after_nonread_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdy_read_o |-> rdy_nonread_o);
endmodule

// File: rtl/refresh_fsm.sv
module refresh_fsm
  import dram_refresh_pkg::*;
#(
  parameter int T_RP  = 3,
  parameter int T_RFC = 20
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      grant_i,
  input  logic      banks_idle_i,
  input  logic      sr_req_i,
  input  logic      pending_i,
  input  logic      nr_expire_i,
  output dram_cmd_e cmd_o,
  output logic      cke_o,
  output logic      ref_req_o,
  output logic      sref_go_o,
  output logic      exit_go_o,
  output logic      aref_go_o,
  output logic      self_mode_o
);
  localparam int CMAX = (T_RP > T_RFC) ? T_RP : T_RFC;
  localparam int CW   = $clog2(CMAX + 1);

  seq_state_e    state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  dram_cmd_e     cmd_q, cmd_d;
  logic          cke_q, cke_d;
  logic          tgt_sr_q, tgt_sr_d;
  logic          want;

  assign want = pending_i || sr_req_i;

  always_comb begin
    state_d   = state_q;
    cnt_d     = cnt_q;
    cmd_d     = CMD_NOP;
    cke_d     = cke_q;
    tgt_sr_d  = tgt_sr_q;
    sref_go_o = 1'b0;
    exit_go_o = 1'b0;
    aref_go_o = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (grant_i && want) begin
          tgt_sr_d = sr_req_i;
          if (!banks_idle_i) begin
            cmd_d   = CMD_PREA;
            cnt_d   = CW'(T_RP - 1);
            state_d = ST_PRE_WAIT;
          end else if (sr_req_i) begin
            cmd_d     = CMD_SREF;
            cke_d     = 1'b0;
            sref_go_o = 1'b1;
            state_d   = ST_SELF;
          end else begin
            cmd_d     = CMD_AREF;
            aref_go_o = 1'b1;
            cnt_d     = CW'(T_RFC - 1);
            state_d   = ST_RFC_WAIT;
          end
        end
      end
      ST_PRE_WAIT: begin
        if (cnt_q != '0) begin
          cnt_d = cnt_q - 1'b1;
        end else if (tgt_sr_q) begin
          cmd_d     = CMD_SREF;
          cke_d     = 1'b0;
          sref_go_o = 1'b1;
          state_d   = ST_SELF;
        end else begin
          cmd_d     = CMD_AREF;
          aref_go_o = 1'b1;
          cnt_d     = CW'(T_RFC - 1);
          state_d   = ST_RFC_WAIT;
        end
      end
      ST_RFC_WAIT: begin
        if (cnt_q != '0) cnt_d = cnt_q - 1'b1;
        else             state_d = ST_IDLE;
      end
      ST_SELF: begin
        if (!sr_req_i) begin
          cke_d     = 1'b1;
          exit_go_o = 1'b1;
          state_d   = ST_EXIT;
        end
      end
      ST_EXIT: begin
        // exit refresh; the interval unit is cleared in this state, so it also restarts the timer
        if (nr_expire_i) begin
          cmd_d   = CMD_AREF;
          cnt_d   = CW'(T_RFC - 1);
          state_d = ST_RFC_WAIT;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      cnt_q    <= '0;
      cmd_q    <= CMD_NOP;
      cke_q    <= 1'b1;
      tgt_sr_q <= 1'b0;
    end else begin
      state_q  <= state_d;
      cnt_q    <= cnt_d;
      cmd_q    <= cmd_d;
      cke_q    <= cke_d;
      tgt_sr_q <= tgt_sr_d;
    end
  end

  assign cmd_o       = cmd_q;
  assign cke_o       = cke_q;
  assign self_mode_o = (state_q == ST_SELF) || (state_q == ST_EXIT);
  assign ref_req_o   = ((state_q == ST_IDLE) && want) || (state_q == ST_PRE_WAIT)
                    || (state_q == ST_RFC_WAIT) || (state_q == ST_EXIT);

  assert_sref_cke_low_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_o == CMD_SREF) |-> !cke_o);
  assert_no_cmd_in_sr_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cke_o |-> (cmd_o == CMD_NOP || cmd_o == CMD_SREF));
  assert_aref_gap_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_o == CMD_AREF) |=> (cmd_o == CMD_NOP));
  assert_cke_rise_nop_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cke_o) |-> (cmd_o == CMD_NOP));
endmodule

// File: rtl/dram_refresh_seq.sv
module dram_refresh_seq
  import dram_refresh_pkg::*;
#(
  parameter int T_REFI   = 1300,
  parameter int MAX_DEBT = 8,
  parameter int T_RP     = 3,
  parameter int T_RFC    = 20,
  parameter int T_XSNR   = 13,
  parameter int T_XSRD   = 200
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       banks_idle_i,
  input  logic       sr_req_i,
  input  logic       grant_i,
  output logic       ref_req_o,
  output logic       ref_urgent_o,
  output logic [1:0] cmd_o,
  output logic       cke_o,
  output logic       rdy_nonread_o,
  output logic       rdy_read_o
);
  dram_cmd_e cmd;
  logic      pending, nr_expire;
  logic      sref_go, exit_go, aref_go, self_mode;

  refresh_interval #(.T_REFI(T_REFI), .MAX_DEBT(MAX_DEBT)) i_interval (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (sref_go || self_mode),
    .dec_i     (aref_go),
    .pending_o (pending),
    .urgent_o  (ref_urgent_o)
  );

  sr_exit_guard #(.T_XSNR(T_XSNR), .T_XSRD(T_XSRD)) i_guard (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .enter_i       (sref_go),
    .exit_i        (exit_go),
    .nr_expire_o   (nr_expire),
    .rdy_nonread_o (rdy_nonread_o),
    .rdy_read_o    (rdy_read_o)
  );

  refresh_fsm #(.T_RP(T_RP), .T_RFC(T_RFC)) i_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .grant_i      (grant_i),
    .banks_idle_i (banks_idle_i),
    .sr_req_i     (sr_req_i),
    .pending_i    (pending),
    .nr_expire_i  (nr_expire),
    .cmd_o        (cmd),
    .cke_o        (cke_o),
    .ref_req_o    (ref_req_o),
    .sref_go_o    (sref_go),
    .exit_go_o    (exit_go),
    .aref_go_o    (aref_go),
    .self_mode_o  (self_mode)
  );

  assign cmd_o = cmd;

  assert_urgent_req_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_urgent_o |-> ref_req_o);
endmodule

// File: tb/test_dram_refresh_seq.sv
module test_dram_refresh_seq;
  localparam int CLK_P = 10;
  localparam int REFI  = 40;
  localparam int MAXD  = 8;
  localparam int RP    = 3;
  localparam int RFC   = 20;
  localparam int XSNR  = 13;
  localparam int XSRD  = 200;
  localparam logic [1:0] C_NOP = 2'b00, C_PREA = 2'b01, C_AREF = 2'b10, C_SREF = 2'b11;
  localparam int M_IDLE = 0, M_RP = 1, M_RFC = 2, M_SR = 3, M_XS = 4;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic banks_idle_i = 1'b1, sr_req_i = 1'b0, grant_i = 1'b0;
  logic ref_req_o, ref_urgent_o, cke_o, rdy_nonread_o, rdy_read_o;
  logic [1:0] cmd_o;

  int n_tests = 0, n_fail = 0;
  bit done = 0;

  dram_refresh_seq #(.T_REFI(REFI), .MAX_DEBT(MAXD), .T_RP(RP), .T_RFC(RFC),
                     .T_XSNR(XSNR), .T_XSRD(XSRD)) i_dram_refresh_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .banks_idle_i(banks_idle_i), .sr_req_i(sr_req_i),
    .grant_i(grant_i), .ref_req_o(ref_req_o), .ref_urgent_o(ref_urgent_o), .cmd_o(cmd_o),
    .cke_o(cke_o), .rdy_nonread_o(rdy_nonread_o), .rdy_read_o(rdy_read_o));

  always #(CLK_P/2) clk_i = ~clk_i;

  // behavioural reference model, absolute cycle stamps
  int n = 0, m_mode = M_IDLE, m_until = 0, m_debt = 0, m_tick_at = REFI;
  int m_nr_at = 0, m_rd_at = 0, m_restart_at = -1000000;
  bit m_tgt = 0, m_rd_wait = 0, f_tick, f_dec, f_clr;
  logic [1:0] e_cmd = C_NOP;
  bit e_cke = 1, e_nr = 1, e_rd = 1;
  string m_tag = "R3";

  task automatic start_target(input bit to_sr);
    if (to_sr) begin
      e_cmd = C_SREF; e_cke = 0; m_mode = M_SR; f_clr = 1;
      e_nr = 0; e_rd = 0; m_rd_wait = 0; m_tag = "R6";
    end else begin
      e_cmd = C_AREF; f_dec = 1; m_mode = M_RFC; m_until = n + RFC; m_tag = "R5";
    end
  endtask

  always @(posedge clk_i) begin
    if (rst_ni) begin
      n++;
      e_cmd = C_NOP; f_dec = 0;
      f_clr = (m_mode == M_SR || m_mode == M_XS);
      f_tick = !f_clr && (n == m_tick_at);
      if (f_tick) m_tick_at += REFI;
      case (m_mode)
        M_IDLE: if (grant_i && (m_debt > 0 || sr_req_i)) begin
          m_tgt = sr_req_i;
          if (!banks_idle_i) begin
            e_cmd = C_PREA; m_mode = M_RP; m_until = n + RP; m_tag = "R4";
          end else start_target(m_tgt);
        end
        M_RP:  if (n == m_until) start_target(m_tgt);
        M_RFC: if (n == m_until) begin m_mode = M_IDLE; m_tag = "R3"; end
        M_SR:  if (!sr_req_i) begin
          e_cke = 1; m_mode = M_XS; m_nr_at = n + XSNR; m_rd_at = n + XSRD;
          m_rd_wait = 1; m_tag = "R7";
        end
        M_XS:  if (n == m_nr_at) begin
          e_cmd = C_AREF; e_nr = 1; m_mode = M_RFC; m_until = n + RFC;
          m_tick_at = n + REFI; m_restart_at = n; m_tag = "R9";
        end
        default: ;
      endcase
      if (m_rd_wait && n == m_rd_at) begin e_rd = 1; m_rd_wait = 0; end
      if (f_clr) m_debt = 0;
      else if (f_tick && !f_dec) m_debt = (m_debt < MAXD) ? m_debt + 1 : MAXD;
      else if (f_dec && !f_tick) m_debt = m_debt - 1;
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s at cycle %0d: act=%0d exp=%0d", req, what, n, act, exp);
    end
  endtask

  always @(posedge clk_i) begin
    #(CLK_P/4);
    if (rst_ni && !done) begin
      bit e_req;
      e_req = (m_mode == M_IDLE && (m_debt > 0 || sr_req_i)) ||
              m_mode == M_RP || m_mode == M_RFC || m_mode == M_XS;
      chk(m_tag, "cmd_o", int'(cmd_o), int'(e_cmd));
      chk("R6", "cke_o", int'(cke_o), int'(e_cke));
      chk("R7", "rdy_nonread_o", int'(rdy_nonread_o), int'(e_nr));
      chk("R8", "rdy_read_o", int'(rdy_read_o), int'(e_rd));
      chk((n < m_restart_at + REFI + 2) ? "R9" : "R2", "ref_req_o", int'(ref_req_o), int'(e_req));
      chk("R1", "ref_urgent_o", int'(ref_urgent_o), int'(m_debt == MAXD));
    end
  end

  task automatic drive(input bit g, input bit bi, input bit sr, input int cycles);
    @(negedge clk_i);
    grant_i = g; banks_idle_i = bi; sr_req_i = sr;
    repeat (cycles - 1) @(negedge clk_i);
  endtask

  task automatic summary;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      done = 1; n_fail++; n_tests++;
      $display("FAIL R3 watchdog: act=running exp=finished");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R10: reset state
    chk("R10", "reset cmd_o", int'(cmd_o), int'(C_NOP));
    chk("R10", "reset cke_o", int'(cke_o), 1);
    chk("R10", "reset rdy_nonread_o", int'(rdy_nonread_o), 1);
    chk("R10", "reset rdy_read_o", int'(rdy_read_o), 1);
    chk("R10", "reset ref_req_o", int'(ref_req_o), 0);
    chk("R10", "reset ref_urgent_o", int'(ref_urgent_o), 0);
    rst_ni = 1'b1;
    // R1: no grant, debt climbs to the ceiling and saturates
    drive(0, 0, 0, 9 * REFI + 5);
    // R4 R5: drain with open banks, then with idle banks
    drive(1, 0, 0, 300);
    drive(1, 1, 0, 100);
    // R6: enter self-refresh with open banks, hold it
    drive(1, 0, 1, 30);
    drive(0, 0, 1, 100);
    // R7 R8 R9: exit and wait out both delays
    drive(1, 1, 0, 260);
    // mixed traffic
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk_i);
      grant_i = ($urandom % 3) != 0;
      banks_idle_i = $urandom % 2;
      if (($urandom % 150) == 0) sr_req_i = ~sr_req_i;
    end
    drive(1, 1, 0, 300);
    done = 1;
    summary();
    $finish;
  end
endmodule